// File: doc/BRIEF.md
# Four-Channel Staged DAC Code Controller

This block takes complete 16-bit command words, already assembled by a serial front end, and turns them into four 12-bit converter codes. Each code is 10 data bits followed by 2 sub-bits. Every channel keeps two stages of storage. A staging register takes new codes. A live register holds the code that is presented to the analog side. Commands can fill a staging register on its own, fill one and publish every channel at once, publish all staged codes, or write one code into every stage of every channel.

Around the channel storage, the block holds a small amount of control state. A sleep flag is set by command, and an enable input can block it. A dropping edge on that enable input wakes the block. There is a general-purpose logic output and a flag that selects the shift-out clock edge. An active-low asynchronous clear returns all of this state to zero. Codes are never lost in sleep, so a wake-up shows the same outputs as before.

Top module: `dacq_top`

## Requirements
- R1: While `clr_n` is low, and right after it falls with no clock edge, `dac_out`, `shutdown`, `user_out` and `dout_rise` are all zero, and every staging register is zero.
- R2: Word fields are: [15:14] channel (0..3, where channel k drives `dac_out[12k+11:12k]`), [13:12] control, [11:2] data, [1:0] sub-bits. Control 01 writes [11:0] into the selected staging register only, and `dac_out` does not change.
- R3: Control 11 writes [11:0] into the selected staging register, and in the same cycle every live register takes its staging value, including the new one.
- R4: Word bits [15:12] = 0100 copy every staging register to its live register and clear `shutdown`.
- R5: Word bits [15:12] = 1000 write [11:0] into all four staging and all four live registers.
- R6: Word bits [15:12] = 1100 set `shutdown` only when `shdn_allow` is high in that cycle, and otherwise leave it unchanged. Staging and live contents are unaffected either way.
- R7: When `shdn_allow` is sampled low after being sampled high, `shutdown` clears with no command word, and `dac_out` keeps its values.
- R8: Word bits [15:12] = 0010 drive `user_out` low, and 0110 drive it high.
- R9: Word bits [15:12] = 1010 set `dout_rise` to 1 and 1110 set it to 0. Both also copy every staging register to its live register.
- R10: Word bits [15:12] = 0000, and any cycle with `word_valid` low, change no state.
- R11: Every command takes effect on the first rising `clk` edge at which `word_valid` is sampled high, so its result is visible in the following cycle. With the default configuration the sub-bits are stored and shown unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| word_valid | input | 1 | Marks `word` as a command for this cycle |
| word | input | 16 | Command word: channel, control, data, sub-bits |
| shdn_allow | input | 1 | High permits sleep; a sampled fall wakes the block |
| dac_out | output | 48 | Four live codes, channel 0 in the low 12 bits |
| shutdown | output | 1 | Sleep flag for the analog side |
| user_out | output | 1 | General-purpose logic output |
| dout_rise | output | 1 | Shift-out edge select: 1 rising, 0 falling |

## Verification
The bench goes after the corners where staging and live storage meet. In a load-and-publish word the new code has to reach the live register in the same cycle, and a design that published the old staged value would show a stale code on the selected channel only. It also puts sleep requests against a low enable, which a careless design would accept, and it drops the enable during sleep, which a design waiting for a command word would leave asleep. A clear raised mid-run without a clock edge, writes with non-zero sub-bits, and a long pseudo-random command stream show whether some code points are misdecoded or the channel select is taken from the wrong bits.

// File: rtl/dacq_pkg.sv
package dacq_pkg;

   // Low two bits of the address/control nibble
   typedef enum logic [1:0] {
      CTL_SYS_A    = 2'b00,
      CTL_LOAD     = 2'b01,
      CTL_SYS_B    = 2'b10,
      CTL_LOAD_UPD = 2'b11
   } ctl_e;

   // One strobe per effect, all produced in the same cycle as word_valid
   typedef struct packed {
      logic ld_one;
      logic upd_all;
      logic ld_all;
      logic sd_req;
      logic exit_sd;
      logic upo_wr;
      logic upo_val;
      logic mode_wr;
      logic mode_val;
   } cmd_t;

endpackage

// File: rtl/dacq_decode.sv
module dacq_decode
   import dacq_pkg::*;
#(
   parameter int ADDR_W    = 2,
   parameter int CODE_W    = 12,
   parameter int SUB_W     = 2,
   parameter bit STORE_SUB = 1'b1,
   localparam int WORD_W   = ADDR_W + 2 + CODE_W
) (
   input  logic              valid,
   input  logic [WORD_W-1:0] word,
   output cmd_t              cmd,
   output logic [ADDR_W-1:0] sel,
   output logic [CODE_W-1:0] code
);

   logic [1:0] ctl;

   assign ctl = word[CODE_W+1:CODE_W];
   assign sel = word[WORD_W-1 -: ADDR_W];

   generate
      if (STORE_SUB) begin : g_keep_sub
         assign code = word[CODE_W-1:0];
      end else begin : g_zero_sub
         assign code = {word[CODE_W-1:SUB_W], {SUB_W{1'b0}}};
      end
   endgenerate

   always_comb begin
      cmd = '0;
      if (valid) begin
         unique case (ctl_e'(ctl))
            CTL_LOAD: cmd.ld_one = 1'b1;
            CTL_LOAD_UPD: begin
               cmd.ld_one  = 1'b1;
               cmd.upd_all = 1'b1;
            end
            CTL_SYS_A: begin
               if (sel == ADDR_W'(1)) begin
                  cmd.upd_all = 1'b1;
                  cmd.exit_sd = 1'b1;
               end else if (sel == ADDR_W'(2)) begin
                  cmd.ld_all = 1'b1;
               end else if (sel == ADDR_W'(3)) begin
                  cmd.sd_req = 1'b1;
               end
            end
            CTL_SYS_B: begin
               if (sel == ADDR_W'(0)) begin
                  cmd.upo_wr  = 1'b1;
                  cmd.upo_val = 1'b0;
               end else if (sel == ADDR_W'(1)) begin
                  cmd.upo_wr  = 1'b1;
                  cmd.upo_val = 1'b1;
               end else if (sel == ADDR_W'(2)) begin
                  cmd.mode_wr  = 1'b1;
                  cmd.mode_val = 1'b1;
                  cmd.upd_all  = 1'b1;
               end else if (sel == ADDR_W'(3)) begin
                  cmd.mode_wr  = 1'b1;
                  cmd.mode_val = 1'b0;
                  cmd.upd_all  = 1'b1;
               end
            end
            default: cmd = '0;
         endcase
      end
   end

endmodule

// File: rtl/dacq_chan.sv
module dacq_chan #(
   parameter int CODE_W = 12
) (
   input  logic              clk,
   input  logic              clr_n,
   input  logic              hit,
   input  logic              ld_one,
   input  logic              ld_all,
   input  logic              upd_all,
   input  logic [CODE_W-1:0] code,
   output logic [CODE_W-1:0] dac_q
);

   logic [CODE_W-1:0] stage_q;
   logic              take;

   assign take = ld_all | (ld_one & hit);

   always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n) begin
         stage_q <= '0;
         dac_q   <= '0;
      end else begin
         if (take) begin
            stage_q <= code;
         end
         if (ld_all) begin
            dac_q <= code;
         end else if (upd_all) begin
            // a code staged in this same cycle goes straight through
            dac_q <= take ? code : stage_q;
         end
      end
   end

endmodule

// File: rtl/dacq_ctrl.sv
module dacq_ctrl (
   input  logic clk,
   input  logic clr_n,
   input  logic allow,
   input  logic sd_req,
   input  logic exit_sd,
   input  logic upo_wr,
   input  logic upo_val,
   input  logic mode_wr,
   input  logic mode_val,
   output logic shutdown,
   output logic user_out,
   output logic dout_rise
);

   logic allow_q;
   logic wake;

   assign wake = allow_q & ~allow;

   always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n) begin
         allow_q   <= 1'b0;
         shutdown  <= 1'b0;
         user_out  <= 1'b0;
         dout_rise <= 1'b0;
      end else begin
         allow_q <= allow;
         if (wake || exit_sd) begin
            shutdown <= 1'b0;
         end else if (sd_req && allow) begin
            shutdown <= 1'b1;
         end
         if (upo_wr) begin
            user_out <= upo_val;
         end
         if (mode_wr) begin
            dout_rise <= mode_val;
         end
      end
   end

endmodule

// File: rtl/dacq_top.sv
module dacq_top
   import dacq_pkg::*;
#(
   parameter int NCH       = 4,
   parameter int DATA_W    = 10,
   parameter int SUB_W     = 2,
   parameter bit STORE_SUB = 1'b1,
   localparam int ADDR_W   = $clog2(NCH),
   localparam int CODE_W   = DATA_W + SUB_W,
   localparam int WORD_W   = ADDR_W + 2 + CODE_W
) (
   input  logic                  clk,
   input  logic                  clr_n,
   input  logic                  word_valid,
   input  logic [WORD_W-1:0]     word,
   input  logic                  shdn_allow,
   output logic [NCH*CODE_W-1:0] dac_out,
   output logic                  shutdown,
   output logic                  user_out,
   output logic                  dout_rise
);

   generate
      if (NCH < 4 || (1 << ADDR_W) != NCH) begin : g_bad_nch
         $error("dacq_top: NCH must be a power of two of at least 4");
      end
      if (DATA_W < 1 || SUB_W < 1) begin : g_bad_code
         $error("dacq_top: DATA_W and SUB_W must both be positive");
      end
   endgenerate

   cmd_t              cmd;
   logic [ADDR_W-1:0] sel;
   logic [CODE_W-1:0] code;

   dacq_decode #(
      .ADDR_W   (ADDR_W),
      .CODE_W   (CODE_W),
      .SUB_W    (SUB_W),
      .STORE_SUB(STORE_SUB)
   ) u_dec (
      .valid(word_valid),
      .word (word),
      .cmd  (cmd),
      .sel  (sel),
      .code (code)
   );

   dacq_ctrl u_ctrl (
      .clk      (clk),
      .clr_n    (clr_n),
      .allow    (shdn_allow),
      .sd_req   (cmd.sd_req),
      .exit_sd  (cmd.exit_sd),
      .upo_wr   (cmd.upo_wr),
      .upo_val  (cmd.upo_val),
      .mode_wr  (cmd.mode_wr),
      .mode_val (cmd.mode_val),
      .shutdown (shutdown),
      .user_out (user_out),
      .dout_rise(dout_rise)
   );

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_ch
         dacq_chan #(
            .CODE_W(CODE_W)
         ) u_chan (
            .clk    (clk),
            .clr_n  (clr_n),
            .hit    (sel == ADDR_W'(i)),
            .ld_one (cmd.ld_one),
            .ld_all (cmd.ld_all),
            .upd_all(cmd.upd_all),
            .code   (code),
            .dac_q  (dac_out[i*CODE_W +: CODE_W])
         );
      end
   endgenerate

endmodule

// File: rtl/dacq_check.sv
module dacq_check #(
   parameter int NCH    = 4,
   parameter int CODE_W = 12,
   parameter int SUB_W  = 2
) (
   input logic                    clk,
   input logic                    clr_n,
   input logic                    word_valid,
   input logic [3:0]              op_bits,
   input logic [CODE_W-SUB_W-1:0] data_bits,
   input logic                    shdn_allow,
   input logic [NCH*CODE_W-1:0]   dac_out,
   input logic                    shutdown,
   input logic                    user_out,
   input logic                    dout_rise
);

   // R1: clear holds every output at zero
   always @(posedge clk) begin
      if (!clr_n) begin
         p_clear_zero_r1: assert (dac_out == '0 && !shutdown && !user_out && !dout_rise)
            else $error("clear state not zero");
      end
   end

   // R2: staging-only load leaves live codes alone
   p_load_only_r2: assert property (@(posedge clk) disable iff (!clr_n)
      (word_valid && op_bits[1:0] == 2'b01) |=> $stable(dac_out));

   // R4: publish-all leaves sleep
   p_upd_exit_r4: assert property (@(posedge clk) disable iff (!clr_n)
      (word_valid && op_bits == 4'b0100) |=> !shutdown);

   // R5: broadcast load reaches channel 0 live register
   p_ldall_r5: assert property (@(posedge clk) disable iff (!clr_n)
      (word_valid && op_bits == 4'b1000) |=> dac_out[CODE_W-1:SUB_W] == $past(data_bits));

   // R6/R7: a low enable never leaves the block asleep
   p_lockout_r6: assert property (@(posedge clk) disable iff (!clr_n)
      !shdn_allow |=> !shutdown);

   // R8: logic output driven high
   p_upo_set_r8: assert property (@(posedge clk) disable iff (!clr_n)
      (word_valid && op_bits == 4'b0110) |=> user_out);

   // R10: idle cycles change nothing visible
   p_idle_r10: assert property (@(posedge clk) disable iff (!clr_n)
      !word_valid |=> ($stable(dac_out) && $stable(user_out) && $stable(dout_rise)));

endmodule

bind dacq_top dacq_check #(
   .NCH   (NCH),
   .CODE_W(CODE_W),
   .SUB_W (SUB_W)
) u_chk (
   .clk       (clk),
   .clr_n     (clr_n),
   .word_valid(word_valid),
   .op_bits   (word[WORD_W-1:CODE_W]),
   .data_bits (word[CODE_W-1:SUB_W]),
   .shdn_allow(shdn_allow),
   .dac_out   (dac_out),
   .shutdown  (shutdown),
   .user_out  (user_out),
   .dout_rise (dout_rise)
);

// File: tb/tb_dacq_top.sv
`timescale 1ns/1ps
module tb_dacq_top;

   logic        clk = 1'b0;
   logic        clr_n = 1'b0;
   logic        word_valid = 1'b0;
   logic [15:0] word = '0;
   logic        shdn_allow = 1'b1;
   logic [47:0] dac_out;
   logic        shutdown, user_out, dout_rise;

   dacq_top dut (
      .clk(clk), .clr_n(clr_n), .word_valid(word_valid), .word(word),
      .shdn_allow(shdn_allow), .dac_out(dac_out), .shutdown(shutdown),
      .user_out(user_out), .dout_rise(dout_rise)
   );

   always #2 clk = ~clk;

   typedef struct {
      logic [47:0] dac;
      logic        sd;
      logic        upo;
      logic        rise;
      string       req;
   } exp_t;

   exp_t q[$];
   int   n_chk = 0;
   int   n_bad = 0;
   bit   done = 0;

   // reference state
   logic [11:0] m_stage [4];
   logic [11:0] m_live  [4];
   logic        m_sd, m_upo, m_rise, m_allow_q;

   function automatic logic [47:0] live_vec();
      return {m_live[3], m_live[2], m_live[1], m_live[0]};
   endfunction

   function automatic void model_clear();
      for (int i = 0; i < 4; i++) begin
         m_stage[i] = '0;
         m_live[i]  = '0;
      end
      m_sd = 0; m_upo = 0; m_rise = 0; m_allow_q = 0;
   endfunction

   function automatic void publish();
      for (int i = 0; i < 4; i++) m_live[i] = m_stage[i];
   endfunction

   function automatic void model_step(logic v, logic [15:0] w, logic allow);
      int a;
      a = int'(w[15:14]);
      if (m_allow_q && !allow) m_sd = 0;
      if (v) begin
         case (w[13:12])
            2'b01: m_stage[a] = w[11:0];
            2'b11: begin m_stage[a] = w[11:0]; publish(); end
            2'b00: case (a)
               1: begin publish(); m_sd = 0; end
               2: for (int i = 0; i < 4; i++) begin
                     m_stage[i] = w[11:0];
                     m_live[i]  = w[11:0];
                  end
               3: if (allow) m_sd = 1;
               default: ;
            endcase
            default: case (a)
               0: m_upo = 0;
               1: m_upo = 1;
               2: begin m_rise = 1; publish(); end
               default: begin m_rise = 0; publish(); end
            endcase
         endcase
      end
      m_allow_q = allow;
   endfunction

   task automatic drive(input logic v, input logic [15:0] w, input logic allow, input string req);
      exp_t e;
      @(negedge clk);
      word_valid = v;
      word       = w;
      shdn_allow = allow;
      model_step(v, w, allow);
      e.dac = live_vec(); e.sd = m_sd; e.upo = m_upo; e.rise = m_rise; e.req = req;
      q.push_back(e);
   endtask

   function automatic logic [15:0] mk(int ch, logic [1:0] ctl, logic [11:0] c);
      return {2'(ch), ctl, c};
   endfunction

   task automatic check_now(input string req);
      n_chk++;
      if (dac_out !== live_vec() || shutdown !== m_sd || user_out !== m_upo || dout_rise !== m_rise) begin
         n_bad++;
         $display("FAIL %s: actual dac=%h sd=%b upo=%b rise=%b expected dac=%h sd=%b upo=%b rise=%b",
                  req, dac_out, shutdown, user_out, dout_rise, live_vec(), m_sd, m_upo, m_rise);
      end
   endtask

   // monitor: compare one expected item per clock, 1 ns after the edge
   always @(posedge clk) begin
      exp_t e;
      #1;
      if (q.size() > 0) begin
         e = q.pop_front();
         n_chk++;
         if (dac_out !== e.dac || shutdown !== e.sd || user_out !== e.upo || dout_rise !== e.rise) begin
            n_bad++;
            $display("FAIL %s: actual dac=%h sd=%b upo=%b rise=%b expected dac=%h sd=%b upo=%b rise=%b",
                     e.req, dac_out, shutdown, user_out, dout_rise, e.dac, e.sd, e.upo, e.rise);
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 4);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
   end

   initial begin
      logic [15:0] lfsr;
      model_clear();
      repeat (3) @(negedge clk);
      check_now("R1 reset");
      @(negedge clk);
      clr_n = 1'b1;

      // R2: staging-only loads, live codes stay zero
      drive(1, mk(0, 2'b01, 12'hABC), 1, "R2 load ch0");
      drive(1, mk(2, 2'b01, 12'h3F0), 1, "R2 load ch2");
      drive(1, mk(3, 2'b01, 12'h00C), 1, "R2 load ch3");
      // R3: load plus publish, new code bypasses
      drive(1, mk(1, 2'b11, 12'h5A5), 1, "R3 load-upd ch1");
      drive(1, mk(2, 2'b01, 12'h111), 1, "R2 restage ch2");
      // R4: publish all
      drive(1, mk(1, 2'b00, 12'hFFF), 1, "R4 publish");
      // R5: broadcast
      drive(1, mk(2, 2'b00, 12'h7E4), 1, "R5 broadcast");
      // R6: sleep allowed, contents kept, commands still accepted
      drive(1, mk(0, 2'b01, 12'h222), 1, "R2 stage before sleep");
      drive(1, mk(3, 2'b00, 12'h000), 1, "R6 sleep allowed");
      drive(1, mk(2, 2'b01, 12'h999), 1, "R6 stage in sleep");
      drive(0, 16'h0000, 1, "R6 stays asleep");
      drive(1, mk(1, 2'b00, 12'h000), 1, "R4 wake by publish");
      // R6: sleep blocked
      drive(1, mk(3, 2'b00, 12'h000), 0, "R6 sleep blocked");
      drive(0, 16'h0000, 1, "R6 still awake");
      // R7: wake on enable drop
      drive(1, mk(3, 2'b00, 12'h000), 1, "R6 sleep again");
      drive(0, 16'h0000, 1, "R7 asleep");
      drive(0, 16'h0000, 0, "R7 wake on drop");
      drive(0, 16'h0000, 0, "R7 stays awake");
      // R8
      drive(1, mk(1, 2'b10, 12'h000), 1, "R8 upo high");
      drive(1, mk(0, 2'b10, 12'hFFF), 1, "R8 upo low");
      drive(1, mk(1, 2'b10, 12'h000), 1, "R8 upo high again");
      // R9
      drive(1, mk(3, 2'b01, 12'h456), 1, "R2 stage ch3");
      drive(1, mk(2, 2'b10, 12'h000), 1, "R9 rising mode");
      drive(1, mk(0, 2'b01, 12'h0F0), 1, "R2 stage ch0");
      drive(1, mk(3, 2'b10, 12'h000), 1, "R9 falling mode");
      // R10: no-op word and idle cycles
      drive(1, mk(1, 2'b01, 12'h321), 1, "R2 stage ch1");
      drive(1, mk(0, 2'b00, 12'hFFF), 1, "R10 nop");
      drive(0, mk(2, 2'b00, 12'h123), 1, "R10 invalid broadcast");
      drive(0, mk(1, 2'b00, 12'h000), 1, "R10 invalid publish");
      // R11: sub-bits kept, single-cycle effect
      drive(1, mk(2, 2'b11, 12'h803), 1, "R11 sub-bits");
      drive(1, mk(1, 2'b00, 12'h000), 1, "R11 publish");
      drive(0, 16'h0000, 1, "R11 idle");

      // R1: asynchronous clear mid-run
      wait (q.size() == 0);
      @(negedge clk);
      clr_n = 1'b0;
      model_clear();
      #0.5;
      check_now("R1 async clear");
      @(negedge clk);
      check_now("R1 clear held");
      clr_n = 1'b1;

      // pseudo-random stream exercising every code point
      lfsr = 16'hACE1;
      for (int k = 0; k < 300; k++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         drive(lfsr[0] | lfsr[5], {lfsr[7:4], lfsr[15:8], lfsr[3:0]}, (k % 7) != 3,
               "R11 random stream");
      end
      drive(0, 16'h0000, 1, "R10 final idle");

      wait (q.size() == 0);
      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule